// File: doc/BRIEF.md
# 4:2:2 Pixel Byte Demultiplexer

This block sits at the input of a composite video encoder. It receives an 8-bit byte stream at the full pixel clock. Each line carries chroma and luma bytes interleaved, and the line starts at the falling edge of an active-low horizontal sync. A small state machine tracks which of the four byte slots in a pixel pair is on the bus. It restarts at slot 0 on every sync fall. Each byte is steered into the luma or chroma holding registers according to two order controls. One control swaps the two chroma components. The other moves luma into the even slots.

Luma is clamped to the legal range 16..235 and chroma to 16..240. Chroma is re-centred so that 128 becomes a signed zero. The block then produces one 4:4:4 sample per luma sample, at half the byte rate. The even luma sample carries the chroma of its own pair. The odd luma sample carries the rounded mean of its own pair's chroma and the next pair's chroma. For this reason a pair is only released once the following pair of the same line has fully arrived.

The state machine has five states:

- `ST_IDLE`: the block waits here after reset, until the first sync fall.
- `ST_SLOT0` to `ST_SLOT3`: each one names the slot of the byte captured at the last edge.

Transitions:

- Any state moves to `ST_SLOT0` on a sync fall (the line-restart transition).
- `ST_IDLE` holds when there is no fall.
- Otherwise the slots advance `ST_SLOT0`→`ST_SLOT1`→`ST_SLOT2`→`ST_SLOT3`→`ST_SLOT0` (the advance transitions).

Top module: `pixel_demux_422`

## Requirements
- R1: While reset is asserted and right after it is released, `out_valid` is 0 and `y_out`, `u_out` and `v_out` are 0.
- R2: Slot 0 is the byte sampled at the clock edge where `hsync_n` is first seen low after being high. Every such fall forces slot 0, whatever slot was in progress, and bytes of an unfinished pair are discarded.
- R3: With both order controls low, the four slots of a pair carry Cb, Y0, Cr, Y1 in that order (slots 0, 1, 2, 3).
- R4: With `cbcr_swap` high, the chroma slot that would carry Cb carries Cr and vice versa.
- R5: With `luma_first` high, luma sits in slots 0 and 2 and chroma in slots 1 and 3: Y0, C-first, Y1, C-second.
- R6: Luma below 16 is output as 16, above 235 as 235, and other values unchanged.
- R7: Chroma is clamped to 16..240 and then offset so that `u_out` = clamped Cb − 128 and `v_out` = clamped Cr − 128, as 9-bit two's complement.
- R8: The first sample of a pair is Y0 with that pair's own chroma. The second sample is Y1 with chroma equal to (c_this + c_next + 1) >> 1 − 128, where c_next is the same component of the following pair.
- R9: The first sample of a pair is presented, with `out_valid` high, right after the clock edge that captures the last byte of the following pair. The second sample is presented two edges later. `out_valid` is never high on two consecutive cycles.
- R10: A pair produces output only if the following pair of the same line completes. Before the first sync fall, and for the last complete pair of a line, no samples are output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Byte clock, two bytes per luma sample |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_n | input | 1 | Active-low horizontal sync; its falling edge starts a line |
| byte_in | input | 8 | Multiplexed luma/chroma byte |
| cbcr_swap | input | 1 | 1: Cr precedes Cb within a pair |
| luma_first | input | 1 | 1: luma in even slots, chroma in odd slots |
| y_out | output | 8 | Clamped luma, unsigned |
| u_out | output | 9 | Blue colour difference, signed |
| v_out | output | 9 | Red colour difference, signed |
| out_valid | output | 1 | One-cycle strobe per output sample |

## Verification
A behavioural model in the bench takes in each byte at the rising edge where the design samples it. Whenever a pair completes and a previous pair of the same line exists, the model queues two expected samples. The first is due on that same edge and the second two edges later, because the design registers each sample once. At every falling clock edge the bench compares the outputs against the head of that queue. It expects `out_valid` high with exact Y, U and V when a sample is due, and `out_valid` low otherwise. This timing check covers every cycle, including line restarts in mid-pair and the quiet stretch before the first sync.

// File: rtl/pxd_pkg.sv
package pxd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SLOT0 = 3'd1,
        ST_SLOT1 = 3'd2,
        ST_SLOT2 = 3'd3,
        ST_SLOT3 = 3'd4
    } slot_e;

    // Steering for the byte sampled at the current edge
    typedef struct packed {
        logic cap_en;     // a byte belongs to a pair this edge
        logic cap_luma;   // byte is luma
        logic cap_hi;     // luma: second sample; unused for chroma
        logic cap_cb;     // chroma byte is Cb
        logic pair_done;  // byte completes the pair
        logic line_start; // sync fall seen at this edge
    } cap_ctl_t;

endpackage

// File: rtl/pxd_clamp.sv
module pxd_clamp #(
    parameter int W  = 8,
    parameter int LO = 16,
    parameter int HI = 235
) (
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    localparam logic [W-1:0] LO_V = W'(LO);
    localparam logic [W-1:0] HI_V = W'(HI);

    always_comb begin
        if (d < LO_V)      q = LO_V;
        else if (d > HI_V) q = HI_V;
        else               q = d;
    end
endmodule

// File: rtl/pxd_phase_fsm.sv
module pxd_phase_fsm
    import pxd_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     hsync_n,
    input  logic     cbcr_swap,
    input  logic     luma_first,
    output cap_ctl_t ctl
);
    slot_e      state_q, adv, slot_now;
    logic       hs_q;
    logic       fall;
    logic [1:0] pos;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            hs_q    <= 1'b1;
        end else begin
            state_q <= slot_now;
            hs_q    <= hsync_n;
        end
    end

    // Next state
    always_comb begin
        fall = hs_q & ~hsync_n;
        unique case (state_q)
            ST_IDLE:  adv = ST_IDLE;
            ST_SLOT0: adv = ST_SLOT1;
            ST_SLOT1: adv = ST_SLOT2;
            ST_SLOT2: adv = ST_SLOT3;
            ST_SLOT3: adv = ST_SLOT0;
            default:  adv = ST_IDLE;
        endcase
        slot_now = fall ? ST_SLOT0 : adv;
    end

    // Outputs: role of the byte on the bus
    always_comb begin
        pos = 2'd0;
        ctl = '0;
        unique case (slot_now)
            ST_IDLE:  ctl.cap_en = 1'b0;
            ST_SLOT0: begin ctl.cap_en = 1'b1; pos = 2'd0; end
            ST_SLOT1: begin ctl.cap_en = 1'b1; pos = 2'd1; end
            ST_SLOT2: begin ctl.cap_en = 1'b1; pos = 2'd2; end
            ST_SLOT3: begin ctl.cap_en = 1'b1; pos = 2'd3; end
            default:  ctl.cap_en = 1'b0;
        endcase
        ctl.cap_luma   = luma_first ? ~pos[0] : pos[0];
        ctl.cap_hi     = pos[1];
        ctl.cap_cb     = ~pos[1] ^ cbcr_swap;
        ctl.pair_done  = (slot_now == ST_SLOT3);
        ctl.line_start = fall;
    end

    // R2
    phase_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_q && !hsync_n) |=> (state_q == ST_SLOT0));

endmodule

// File: rtl/pxd_upsample.sv
module pxd_upsample
    import pxd_pkg::*;
#(
    parameter int DW  = 8,
    parameter int YLO = 16,
    parameter int YHI = 235,
    parameter int CLO = 16,
    parameter int CHI = 240
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  cap_ctl_t             ctl,
    input  logic [DW-1:0]        y_in,
    input  logic [DW-1:0]        c_in,
    output logic [DW-1:0]        y_out,
    output logic signed [DW:0]   u_out,
    output logic signed [DW:0]   v_out,
    output logic                 out_valid
);
    localparam int SW   = DW + 1;
    localparam int ZERO = 1 << (DW - 1);
    localparam logic [SW-1:0] ZERO_V = SW'(ZERO);

    logic [DW-1:0] cap_y0, cap_y1, cap_cb, cap_cr;
    logic [DW-1:0] cur_y0, cur_y1, cur_cb, cur_cr;
    logic [DW-1:0] prv_y0, prv_y1, prv_cb, prv_cr;
    logic          prv_ok;
    logic [DW-1:0] pend_y;
    logic [SW-1:0] pend_u, pend_v;
    logic          pend_arm, pend_go;
    logic [DW:0]   sum_u, sum_v;

    // The pair as it stands including the byte of this edge
    always_comb begin
        cur_y0 = (ctl.cap_en &  ctl.cap_luma & ~ctl.cap_hi) ? y_in : cap_y0;
        cur_y1 = (ctl.cap_en &  ctl.cap_luma &  ctl.cap_hi) ? y_in : cap_y1;
        cur_cb = (ctl.cap_en & ~ctl.cap_luma &  ctl.cap_cb) ? c_in : cap_cb;
        cur_cr = (ctl.cap_en & ~ctl.cap_luma & ~ctl.cap_cb) ? c_in : cap_cr;
        sum_u  = {1'b0, prv_cb} + {1'b0, cur_cb} + 1'b1;
        sum_v  = {1'b0, prv_cr} + {1'b0, cur_cr} + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_y0 <= '0; cap_y1 <= '0; cap_cb <= '0; cap_cr <= '0;
            prv_y0 <= '0; prv_y1 <= '0; prv_cb <= '0; prv_cr <= '0;
            prv_ok <= 1'b0;
            pend_y <= '0; pend_u <= '0; pend_v <= '0;
            pend_arm <= 1'b0; pend_go <= 1'b0;
            y_out <= '0; u_out <= '0; v_out <= '0; out_valid <= 1'b0;
        end else begin
            cap_y0 <= cur_y0; cap_y1 <= cur_y1;
            cap_cb <= cur_cb; cap_cr <= cur_cr;
            out_valid <= 1'b0;
            pend_go   <= pend_arm;
            pend_arm  <= 1'b0;
            if (ctl.line_start) prv_ok <= 1'b0;
            if (pend_go) begin
                y_out     <= pend_y;
                u_out     <= $signed(pend_u);
                v_out     <= $signed(pend_v);
                out_valid <= 1'b1;
            end
            if (ctl.pair_done) begin
                if (prv_ok) begin
                    y_out     <= prv_y0;
                    u_out     <= $signed({1'b0, prv_cb} - ZERO_V);
                    v_out     <= $signed({1'b0, prv_cr} - ZERO_V);
                    out_valid <= 1'b1;
                    pend_y    <= prv_y1;
                    pend_u    <= {1'b0, sum_u[DW:1]} - ZERO_V;
                    pend_v    <= {1'b0, sum_v[DW:1]} - ZERO_V;
                    pend_arm  <= 1'b1;
                end
                prv_y0 <= cur_y0; prv_y1 <= cur_y1;
                prv_cb <= cur_cb; prv_cr <= cur_cr;
                prv_ok <= 1'b1;
            end
        end
    end

    // R9
    valid_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R6
    luma_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (y_out >= DW'(YLO)) && (y_out <= DW'(YHI)));

    // R7
    u_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (int'(u_out) >= CLO - ZERO) && (int'(u_out) <= CHI - ZERO));

    // R7
    v_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (int'(v_out) >= CLO - ZERO) && (int'(v_out) <= CHI - ZERO));

endmodule

// File: rtl/pixel_demux_422.sv
module pixel_demux_422
    import pxd_pkg::*;
#(
    parameter int DW    = 8,
    parameter int Y_MIN = 16,
    parameter int Y_MAX = 235,
    parameter int C_MIN = 16,
    parameter int C_MAX = 240
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 hsync_n,
    input  logic [DW-1:0]        byte_in,
    input  logic                 cbcr_swap,
    input  logic                 luma_first,
    output logic [DW-1:0]        y_out,
    output logic signed [DW:0]   u_out,
    output logic signed [DW:0]   v_out,
    output logic                 out_valid
);
    cap_ctl_t      ctl;
    logic [DW-1:0] y_lim, c_lim;

    pxd_phase_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .hsync_n    (hsync_n),
        .cbcr_swap  (cbcr_swap),
        .luma_first (luma_first),
        .ctl        (ctl)
    );

    pxd_clamp #(.W(DW), .LO(Y_MIN), .HI(Y_MAX)) u_yclamp (
        .d (byte_in),
        .q (y_lim)
    );

    pxd_clamp #(.W(DW), .LO(C_MIN), .HI(C_MAX)) u_cclamp (
        .d (byte_in),
        .q (c_lim)
    );

    pxd_upsample #(
        .DW(DW), .YLO(Y_MIN), .YHI(Y_MAX), .CLO(C_MIN), .CHI(C_MAX)
    ) u_ups (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl       (ctl),
        .y_in      (y_lim),
        .c_in      (c_lim),
        .y_out     (y_out),
        .u_out     (u_out),
        .v_out     (v_out),
        .out_valid (out_valid)
    );

endmodule

// File: tb/pixel_demux_422_tb.sv
module pixel_demux_422_tb;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              hsync_n = 1'b1;
    logic [7:0]        byte_in = '0;
    logic              cbcr_swap = 1'b0;
    logic              luma_first = 1'b0;
    logic [7:0]        y_out;
    logic signed [8:0] u_out, v_out;
    logic              out_valid;

    int checks = 0;
    int fails  = 0;
    string sc_tag = "R10";

    always #4 clk = ~clk;

    pixel_demux_422 u_dut (
        .clk(clk), .rst_n(rst_n), .hsync_n(hsync_n), .byte_in(byte_in),
        .cbcr_swap(cbcr_swap), .luma_first(luma_first),
        .y_out(y_out), .u_out(u_out), .v_out(v_out), .out_valid(out_valid)
    );

    // ---------------- behavioural reference ----------------
    int    edge_no = 0;
    int    phase = -1;
    bit    prev_hs = 1'b1;
    int    pb[4];
    bit    have_prev = 1'b0;
    int    p_y0, p_y1, p_cb, p_cr;
    int    q_due[$], q_y[$], q_u[$], q_v[$];
    string q_req[$];

    function automatic int lim(int v, int lo, int hi);
        return (v < lo) ? lo : ((v > hi) ? hi : v);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            prev_hs = 1'b1; phase = -1; have_prev = 1'b0;
        end else begin
            edge_no++;
            if (prev_hs && !hsync_n) begin
                phase = 0; have_prev = 1'b0;
            end else if (phase >= 0) begin
                phase = (phase + 1) % 4;
            end
            prev_hs = hsync_n;
            if (phase >= 0) begin
                pb[phase] = int'(byte_in);
                if (phase == 3) begin
                    int ya, yb, c1, c2, cb, cr;
                    if (!luma_first) begin ya = pb[1]; yb = pb[3]; c1 = pb[0]; c2 = pb[2]; end
                    else             begin ya = pb[0]; yb = pb[2]; c1 = pb[1]; c2 = pb[3]; end
                    cb = cbcr_swap ? c2 : c1;
                    cr = cbcr_swap ? c1 : c2;
                    ya = lim(ya, 16, 235); yb = lim(yb, 16, 235);
                    cb = lim(cb, 16, 240); cr = lim(cr, 16, 240);
                    if (have_prev) begin
                        q_due.push_back(edge_no);     q_y.push_back(p_y0);
                        q_u.push_back(p_cb - 128);    q_v.push_back(p_cr - 128);
                        q_req.push_back(sc_tag);
                        q_due.push_back(edge_no + 2); q_y.push_back(p_y1);
                        q_u.push_back((p_cb + cb + 1) / 2 - 128);
                        q_v.push_back((p_cr + cr + 1) / 2 - 128);
                        q_req.push_back("R8");
                    end
                    p_y0 = ya; p_y1 = yb; p_cb = cb; p_cr = cr;
                    have_prev = 1'b1;
                end
            end
        end
    end

    // ---------------- per-cycle comparison ----------------
    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (q_due.size() > 0 && q_due[0] == edge_no) begin
                int ey, eu, ev;
                string rq;
                ey = q_y.pop_front(); eu = q_u.pop_front(); ev = q_v.pop_front();
                rq = q_req.pop_front(); void'(q_due.pop_front());
                if (!out_valid || int'(y_out) != ey || int'(u_out) != eu || int'(v_out) != ev) begin
                    fails++;
                    $display("FAIL %s edge %0d: valid=%0d y=%0d u=%0d v=%0d expected valid=1 y=%0d u=%0d v=%0d",
                             rq, edge_no, out_valid, y_out, int'(u_out), int'(v_out), ey, eu, ev);
                end
            end else if (out_valid) begin
                fails++;
                $display("FAIL R9 (%s) edge %0d: valid=1 expected valid=0", sc_tag, edge_no);
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic send_line(string tag, bit sw_c, bit sw_y, int n, int mode, int seed);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (k == 0) begin sc_tag = tag; cbcr_swap = sw_c; luma_first = sw_y; end
            hsync_n = (k < 3) ? 1'b0 : 1'b1;
            case (mode)
                0: byte_in = 8'((k * 53 + seed) & 255);
                1: byte_in = (k % 2 == 0) ? 8'd3 : 8'd252;
                2: byte_in = (k % 2 == 0) ? 8'd250 : 8'd9;
                default: byte_in = 8'd128 + 8'(k % 4);
            endcase
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state right after release
        checks++;
        if (out_valid !== 1'b0 || y_out !== 8'd0 || u_out !== 9'sd0 || v_out !== 9'sd0) begin
            fails++;
            $display("FAIL R1: valid=%0d y=%0d u=%0d v=%0d expected all 0",
                     out_valid, y_out, int'(u_out), int'(v_out));
        end
        // R10: bytes before any sync fall produce nothing
        for (int k = 0; k < 24; k++) begin
            @(negedge clk);
            byte_in = 8'(k * 17);
        end
        send_line("R3", 1'b0, 1'b0, 40, 0, 7);
        send_line("R4", 1'b1, 1'b0, 40, 0, 91);
        send_line("R5", 1'b0, 1'b1, 40, 0, 33);
        send_line("R5", 1'b1, 1'b1, 40, 0, 160);
        // R2: line restarted in mid-pair, several lengths
        send_line("R2", 1'b0, 1'b0, 14, 0, 5);
        send_line("R2", 1'b0, 1'b0, 13, 0, 77);
        send_line("R2", 1'b1, 1'b1, 15, 0, 201);
        send_line("R3", 1'b0, 1'b0, 24, 0, 140);
        // R6 / R7: out-of-range bytes
        send_line("R6", 1'b0, 1'b0, 32, 1, 0);
        send_line("R7", 1'b0, 1'b1, 32, 1, 0);
        send_line("R7", 1'b0, 1'b0, 32, 2, 0);
        send_line("R6", 1'b1, 1'b1, 32, 2, 0);
        send_line("R8", 1'b0, 1'b0, 32, 3, 0);
        // R10: tail of the last line drains
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            byte_in = 8'd128;
        end
        if (q_due.size() != 0) begin
            checks++; fails++;
            $display("FAIL R9: %0d expected samples never seen, expected 0", q_due.size());
        end
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end

endmodule